// File: doc/BRIEF.md
# Register-Bank Error Exception Entry Sequencer

This block carries out the entry into a register-bank error exception. A one-cycle pulse on the overflow or the underflow trigger starts a fixed sequence on a single word-wide memory port. First the handler start address for that error kind is read from a vector table. Next the status word is pushed onto the stack, and then the program counter is pushed after it. Finally the block redirects execution with a one-cycle PC load to the fetched handler and writes the lowered stack pointer back. The processor core holds the stack pointer and the status register. The sequencer reads their current values and returns updated values through load strobes.

The two error kinds differ in two ways. An overflow pushes the address of the instruction after the last one that completed. It also writes the priority of the interrupt that caused it into the 4-bit mask field of the status register, so that the same interrupt cannot nest. An underflow pushes the address of the faulting bank-restore instruction and leaves the status register unchanged. The states are IDLE, VEC_RD, SR_PUSH, PC_PUSH and JUMP. The transitions are: IDLE to VEC_RD on a trigger; VEC_RD to SR_PUSH on the read acknowledge; SR_PUSH to PC_PUSH on the first write acknowledge; PC_PUSH to JUMP on the second write acknowledge; and JUMP to IDLE unconditionally after one cycle.

Top module: `bank_err_entry_seq`

## Requirements
- R1: While reset is asserted and afterwards until a trigger, `busy`, `mem_req`, `pc_load`, `sp_load` and `sr_load` are all low.
- R2: The first memory access after a trigger is a single read (`mem_we`=0) of one 32-bit word at `vec_base + 0x2C` for overflow or `vec_base + 0x30` for underflow. The word returned becomes the handler address.
- R3: The second access is a write (`mem_we`=1) at the stack pointer minus 4. The data is the status word as it was sampled in the trigger cycle, before any mask update.
- R4: The third access is a write at the stack pointer minus 8. The data is `next_pc` for overflow or `fault_pc` for underflow, each sampled in the trigger cycle.
- R5: In the cycle after the third acknowledge, `pc_load` is high for exactly one cycle with `pc_target` equal to the handler address. In that same cycle `sp_load` is high with `sp_next` equal to the sampled stack pointer minus 8.
- R6: For overflow, `sr_load` is high together with `pc_load`. `sr_next` equals the sampled status word with bits 7:4 replaced by `irq_level`, and all other bits unchanged. For underflow, `sr_load` stays low.
- R7: `busy` is high from the cycle after an accepted trigger through the `pc_load` cycle. Triggers seen while `busy` is high, including in the `pc_load` cycle, are ignored and start no further access.
- R8: When both triggers arrive in the same idle cycle, the overflow sequence is the one run.
- R9: Each access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack` and then moves on. With w wait cycles per access, `pc_load` rises 4 + 3w cycles after the trigger cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_req | input | 1 | Bank overflow trigger pulse |
| unf_req | input | 1 | Bank underflow trigger pulse |
| irq_level | input | 4 | Priority of the interrupt causing an overflow |
| next_pc | input | 32 | Address of the instruction after the last completed one |
| fault_pc | input | 32 | Address of the faulting bank-restore instruction |
| vec_base | input | 32 | Base address of the exception vector table |
| sp_cur | input | 32 | Current stack pointer |
| sr_cur | input | 32 | Current status register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| sp_load | output | 1 | Write sp_next into the stack pointer |
| sp_next | output | 32 | New stack pointer |
| sr_load | output | 1 | Write sr_next into the status register |
| sr_next | output | 32 | New status word |
| pc_load | output | 1 | Redirect execution to pc_target |
| pc_target | output | 32 | Handler start address |
| busy | output | 1 | Sequence in progress |

## Verification
Two events can fall in the same cycle. One is a fresh trigger. The other is the final JUMP cycle, in which `pc_load` is high and the sequencer is about to return to idle. The bench raises a trigger exactly in the cycle in which it observes `pc_load`. It then checks that `busy` falls on the next cycle, and that the read and write logs gain no entry over the following cycles. A second collision, in which both triggers arrive together, is judged by the vector address read and the PC value pushed.

// File: rtl/bank_err_pkg.sv
package bank_err_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC_RD,
        ST_SR_PUSH,
        ST_PC_PUSH,
        ST_JUMP
    } bes_state_e;

    typedef enum logic {
        KIND_UNF = 1'b0,
        KIND_OVF = 1'b1
    } bes_kind_e;

    // Replace a MW-bit field starting at LSB with val; all other bits kept.
    function automatic logic [31:0] put_mask(
        input logic [31:0] word,
        input logic [31:0] val,
        input int unsigned lsb,
        input int unsigned mw
    );
        logic [31:0] fmask;
        fmask = ((32'd1 << mw) - 32'd1) << lsb;
        return (word & ~fmask) | ((val << lsb) & fmask);
    endfunction

endpackage

// File: rtl/bes_ctrl.sv
module bes_ctrl
    import bank_err_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_req,
    input  logic       unf_req,
    input  logic       mem_ack,
    output bes_state_e state,
    output logic       start,
    output bes_kind_e  start_kind,
    output logic       cap_vec,
    output logic       busy
);

    bes_state_e state_q;
    bes_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (ovf_req || unf_req) state_d = ST_VEC_RD;
            ST_VEC_RD:  if (mem_ack)            state_d = ST_SR_PUSH;
            ST_SR_PUSH: if (mem_ack)            state_d = ST_PC_PUSH;
            ST_PC_PUSH: if (mem_ack)            state_d = ST_JUMP;
            ST_JUMP:                            state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start      = 1'b0;
        start_kind = ovf_req ? KIND_OVF : KIND_UNF;
        cap_vec    = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy  = 1'b0;
                start = ovf_req || unf_req;
            end
            ST_VEC_RD:  cap_vec = mem_ack;
            ST_SR_PUSH: ;
            ST_PC_PUSH: ;
            ST_JUMP:    ;
            default:    busy = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bes_ctx.sv
module bes_ctx
    import bank_err_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int LVW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  bes_kind_e      start_kind,
    input  logic           cap_vec,
    input  logic [LVW-1:0] irq_level,
    input  logic [AW-1:0]  next_pc,
    input  logic [AW-1:0]  fault_pc,
    input  logic [AW-1:0]  sp_cur,
    input  logic [DW-1:0]  sr_cur,
    input  logic [DW-1:0]  mem_rdata,
    output bes_kind_e      kind,
    output logic [LVW-1:0] level,
    output logic [AW-1:0]  saved_pc,
    output logic [AW-1:0]  saved_sp,
    output logic [DW-1:0]  saved_sr,
    output logic [AW-1:0]  handler
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind     <= KIND_UNF;
            level    <= '0;
            saved_pc <= '0;
            saved_sp <= '0;
            saved_sr <= '0;
        end else if (start) begin
            kind     <= start_kind;
            level    <= irq_level;
            saved_pc <= (start_kind == KIND_OVF) ? next_pc : fault_pc;
            saved_sp <= sp_cur;
            saved_sr <= sr_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       handler <= '0;
        else if (cap_vec) handler <= mem_rdata[AW-1:0];
    end

endmodule

// File: rtl/bes_mem_mux.sv
module bes_mem_mux
    import bank_err_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          DW         = 32,
    parameter int          WORD_BYTES = 4,
    parameter logic [31:0] OVF_OFS    = 32'h2C,
    parameter logic [31:0] UNF_OFS    = 32'h30
) (
    input  bes_state_e    state,
    input  bes_kind_e     kind,
    input  logic [AW-1:0] vec_base,
    input  logic [AW-1:0] saved_sp,
    input  logic [DW-1:0] saved_sr,
    input  logic [AW-1:0] saved_pc,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    localparam logic [AW-1:0] STEP1 = AW'(WORD_BYTES);
    localparam logic [AW-1:0] STEP2 = AW'(2 * WORD_BYTES);

    logic [AW-1:0] vec_addr;
    assign vec_addr = vec_base + ((kind == KIND_OVF) ? AW'(OVF_OFS) : AW'(UNF_OFS));

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_SR_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = saved_sp - STEP1;
                mem_wdata = saved_sr;
            end
            ST_PC_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = saved_sp - STEP2;
                mem_wdata = DW'(saved_pc);
            end
            ST_IDLE, ST_JUMP: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/bank_err_entry_seq.sv
module bank_err_entry_seq
    import bank_err_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          DW         = 32,
    parameter int          LVW        = 4,
    parameter int          MASK_LSB   = 4,
    parameter int          WORD_BYTES = 4,
    parameter logic [31:0] OVF_OFS    = 32'h2C,
    parameter logic [31:0] UNF_OFS    = 32'h30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ovf_req,
    input  logic           unf_req,
    input  logic [LVW-1:0] irq_level,
    input  logic [AW-1:0]  next_pc,
    input  logic [AW-1:0]  fault_pc,
    input  logic [AW-1:0]  vec_base,
    input  logic [AW-1:0]  sp_cur,
    input  logic [DW-1:0]  sr_cur,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic           sp_load,
    output logic [AW-1:0]  sp_next,
    output logic           sr_load,
    output logic [DW-1:0]  sr_next,
    output logic           pc_load,
    output logic [AW-1:0]  pc_target,
    output logic           busy
);

    localparam logic [AW-1:0] FRAME = AW'(2 * WORD_BYTES);

    bes_state_e     state;
    logic           start;
    bes_kind_e      start_kind;
    logic           cap_vec;
    bes_kind_e      kind;
    logic [LVW-1:0] level;
    logic [AW-1:0]  saved_pc;
    logic [AW-1:0]  saved_sp;
    logic [DW-1:0]  saved_sr;
    logic [AW-1:0]  handler;

    bes_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_req    (ovf_req),
        .unf_req    (unf_req),
        .mem_ack    (mem_ack),
        .state      (state),
        .start      (start),
        .start_kind (start_kind),
        .cap_vec    (cap_vec),
        .busy       (busy)
    );

    bes_ctx #(.AW(AW), .DW(DW), .LVW(LVW)) u_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (start_kind),
        .cap_vec    (cap_vec),
        .irq_level  (irq_level),
        .next_pc    (next_pc),
        .fault_pc   (fault_pc),
        .sp_cur     (sp_cur),
        .sr_cur     (sr_cur),
        .mem_rdata  (mem_rdata),
        .kind       (kind),
        .level      (level),
        .saved_pc   (saved_pc),
        .saved_sp   (saved_sp),
        .saved_sr   (saved_sr),
        .handler    (handler)
    );

    bes_mem_mux #(
        .AW(AW), .DW(DW), .WORD_BYTES(WORD_BYTES),
        .OVF_OFS(OVF_OFS), .UNF_OFS(UNF_OFS)
    ) u_mux (
        .state      (state),
        .kind       (kind),
        .vec_base   (vec_base),
        .saved_sp   (saved_sp),
        .saved_sr   (saved_sr),
        .saved_pc   (saved_pc),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    // Redirect stage: all loads share the JUMP cycle.
    logic in_jump;
    assign in_jump   = (state == ST_JUMP);
    assign pc_load   = in_jump;
    assign pc_target = handler;
    assign sp_load   = in_jump;
    assign sp_next   = saved_sp - FRAME;
    assign sr_load   = in_jump && (kind == KIND_OVF);
    assign sr_next   = DW'(put_mask(32'(saved_sr), 32'(level), MASK_LSB, LVW));

endmodule

// File: rtl/bes_chk.sv
module bes_chk (
    input logic clk,
    input logic rst_n,
    input logic ovf_req,
    input logic unf_req,
    input logic busy,
    input logic mem_req,
    input logic mem_we,
    input logic mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic pc_load,
    input logic sp_load,
    input logic sr_load
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !pc_load && !sp_load && !sr_load));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
                                   && $stable(mem_addr) && $stable(mem_wdata)));

    assert_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    assert_sp_with_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |-> pc_load);

    assert_sr_with_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load |-> pc_load);

    assert_jump_no_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (busy && !mem_req));

    assert_trigger_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (ovf_req || unf_req)) |=> (busy && mem_req && !mem_we));

endmodule

bind bank_err_entry_seq bes_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovf_req   (ovf_req),
    .unf_req   (unf_req),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_load   (pc_load),
    .sp_load   (sp_load),
    .sr_load   (sr_load)
);

// File: tb/bank_err_entry_seq_tb.sv
module bank_err_entry_seq_tb;

    localparam logic [31:0] H_OVF = 32'h0000_8A00;
    localparam logic [31:0] H_UNF = 32'h0000_8B40;

    typedef struct packed {
        logic        ovf;
        logic [3:0]  lvl;
        logic [1:0]  wt;
        logic [31:0] sr;
        logic [31:0] sp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd5,  2'd0, 32'h0000_00F0, 32'h0000_2000},
        '{1'b0, 4'd9,  2'd0, 32'h4000_0300, 32'h0000_3F00},
        '{1'b1, 4'd15, 2'd1, 32'h1234_5678, 32'h0001_0000},
        '{1'b0, 4'd0,  2'd2, 32'hFFFF_FFFF, 32'h0000_0008},
        '{1'b1, 4'd0,  2'd3, 32'hFFFF_FF0F, 32'hFFFF_FFF0},
        '{1'b1, 4'd12, 2'd2, 32'h0000_0000, 32'h0000_0004}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ovf_req, unf_req;
    logic [3:0]  irq_level;
    logic [31:0] next_pc, fault_pc, vec_base, sp_cur, sr_cur;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        sp_load, sr_load, pc_load, busy;
    logic [31:0] sp_next, sr_next, pc_target;

    always #4 clk = ~clk;

    bank_err_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ovf_req(ovf_req), .unf_req(unf_req),
        .irq_level(irq_level), .next_pc(next_pc), .fault_pc(fault_pc),
        .vec_base(vec_base), .sp_cur(sp_cur), .sr_cur(sr_cur),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .sp_load(sp_load), .sp_next(sp_next), .sr_load(sr_load),
        .sr_next(sr_next), .pc_load(pc_load), .pc_target(pc_target),
        .busy(busy)
    );

    // memory model with programmable wait
    logic [1:0] wait_cfg;
    logic [1:0] wcnt;
    always @(posedge clk) begin
        if (!mem_req || mem_ack) wcnt <= 2'd0;
        else                     wcnt <= wcnt + 2'd1;
    end
    assign mem_ack   = mem_req && (wcnt == wait_cfg);
    assign mem_rdata = (mem_addr == vec_base + 32'h2C) ? H_OVF :
                       (mem_addr == vec_base + 32'h30) ? H_UNF : 32'hDEAD_BEEF;

    // access log
    logic        log_clr;
    int          rd_cnt, wr_cnt;
    logic [31:0] rd_a;
    logic [31:0] wr_a [4];
    logic [31:0] wr_d [4];
    always @(posedge clk) begin
        if (log_clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else if (mem_req && mem_ack) begin
            if (mem_we) begin
                if (wr_cnt < 4) begin
                    wr_a[wr_cnt] <= mem_addr;
                    wr_d[wr_cnt] <= mem_wdata;
                end
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_a   <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One exception entry; expected values computed from the requirements.
    task automatic run(input bit ovf, input bit unf, input logic [3:0] lvl,
                       input logic [1:0] w, input logic [31:0] sr,
                       input logic [31:0] sp, input logic [31:0] npc,
                       input logic [31:0] fpc, input bit mid_trig,
                       input bit end_trig);
        bit          take_ovf;
        int          lat;
        logic [31:0] got_tgt, got_sp, got_sr;
        logic        got_spl, got_srl;
        logic [31:0] exp_sr;
        take_ovf = ovf;
        exp_sr   = (sr & ~32'h0000_00F0) | (32'(lvl) << 4);
        @(negedge clk);
        log_clr   = 1'b0;
        wait_cfg  = w;
        irq_level = lvl;
        sr_cur    = sr;
        sp_cur    = sp;
        next_pc   = npc;
        fault_pc  = fpc;
        ovf_req   = ovf;
        unf_req   = unf;
        lat       = 0;
        got_tgt = '0; got_sp = '0; got_sr = '0; got_spl = 0; got_srl = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            ovf_req = 1'b0;
            unf_req = 1'b0;
            // context changes mid-sequence must not matter
            sr_cur  = ~sr;
            sp_cur  = sp + 32'h100;
            next_pc = 32'hBAD0_0000;
            fault_pc = 32'hBAD0_0004;
            irq_level = ~lvl;
            if (k == 1) chk(busy === 1'b1, "R7 busy after trigger", 32'(busy), 32'd1);
            if (mid_trig && k == 2) unf_req = 1'b1;
            if (mid_trig && k == 2) ovf_req = 1'b1;
            if (pc_load === 1'b1) begin
                lat = k;
                got_tgt = pc_target; got_spl = sp_load; got_sp = sp_next;
                got_srl = sr_load;   got_sr = sr_next;
                chk(busy === 1'b1, "R7 busy in load cycle", 32'(busy), 32'd1);
                if (end_trig) unf_req = 1'b1;
                break;
            end
        end
        chk(lat == 4 + 3 * int'(w), "R9 latency", 32'(lat), 32'(4 + 3 * int'(w)));
        chk(got_tgt === (take_ovf ? H_OVF : H_UNF), "R5 pc_target", got_tgt, take_ovf ? H_OVF : H_UNF);
        chk(got_spl === 1'b1 && got_sp === sp - 32'd8, "R5 sp_next", got_sp, sp - 32'd8);
        if (take_ovf) begin
            chk(got_srl === 1'b1, "R6 sr_load ovf", 32'(got_srl), 32'd1);
            chk(got_sr === exp_sr, "R6 sr_next", got_sr, exp_sr);
        end else begin
            chk(got_srl === 1'b0, "R6 sr_load unf", 32'(got_srl), 32'd0);
        end
        chk(rd_cnt == 1, "R2 read count", 32'(rd_cnt), 32'd1);
        chk(rd_a === vec_base + (take_ovf ? 32'h2C : 32'h30), "R2 vector addr",
            rd_a, vec_base + (take_ovf ? 32'h2C : 32'h30));
        chk(wr_cnt == 2, "R3 write count", 32'(wr_cnt), 32'd2);
        chk(wr_a[0] === sp - 32'd4, "R3 SR push addr", wr_a[0], sp - 32'd4);
        chk(wr_d[0] === sr, "R3 SR push data", wr_d[0], sr);
        chk(wr_a[1] === sp - 32'd8, "R4 PC push addr", wr_a[1], sp - 32'd8);
        chk(wr_d[1] === (take_ovf ? npc : fpc), "R4 PC push data", wr_d[1], take_ovf ? npc : fpc);
        @(negedge clk);
        unf_req = 1'b0;
        chk(busy === 1'b0, "R7 idle after load", 32'(busy), 32'd0);
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && rd_cnt == 1 && wr_cnt == 2, "R7 no restart",
            32'(rd_cnt + wr_cnt), 32'd3);
        log_clr = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ovf_req = 1'b0; unf_req = 1'b0; irq_level = '0;
        next_pc = '0; fault_pc = '0; vec_base = 32'h0000_0400;
        sp_cur = '0; sr_cur = '0; wait_cfg = 2'd0; log_clr = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state, with a trigger present during reset
        ovf_req = 1'b1;
        @(negedge clk);
        chk({busy, mem_req, pc_load, sp_load, sr_load} === 5'b0, "R1 reset outputs",
            32'({busy, mem_req, pc_load, sp_load, sr_load}), 32'd0);
        ovf_req = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, mem_req, pc_load, sp_load, sr_load} === 5'b0, "R1 idle after reset",
            32'({busy, mem_req, pc_load, sp_load, sr_load}), 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            run(VECS[i].ovf, !VECS[i].ovf, VECS[i].lvl, VECS[i].wt, VECS[i].sr,
                VECS[i].sp, 32'h1000_0000 + 32'(i * 16), 32'h1000_0008 + 32'(i * 16),
                1'b0, 1'b0);
        end

        // R8: both triggers together -> overflow
        run(1'b1, 1'b1, 4'd7, 2'd1, 32'h0000_0A5A, 32'h0000_5000,
            32'h2000_0010, 32'h2000_0020, 1'b0, 1'b0);
        // R7: triggers mid-sequence are ignored
        run(1'b0, 1'b1, 4'd3, 2'd2, 32'h0000_1111, 32'h0000_6000,
            32'h2000_0030, 32'h2000_0040, 1'b1, 1'b0);
        // R7: trigger in the pc_load cycle is ignored
        vec_base = 32'h0001_0000;
        run(1'b1, 1'b0, 4'd2, 2'd0, 32'h0000_2222, 32'h0000_7000,
            32'h2000_0050, 32'h2000_0060, 1'b0, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule